// File: doc/BRIEF.md
# Sync-Aligned Pixel Counter with Gain Steering

This block keeps the horizontal pixel index for an image sensor front end. It runs on the pixel clock and counts one pixel per clock. It restarts the count at zero a fixed number of clocks after a chosen horizontal sync edge, so that the index lines up with the delay through the sampling pipeline. Between restarts the counter either wraps back to zero after a programmed maximum or freezes at that maximum until horizontal sync next goes high.

Alongside the count, the block produces a 2-bit gain-register index for a per-pixel programmable gain stage that serves a two-by-two colour mosaic. Bit 0 is the pixel phase and alternates on every counted pixel. Bit 1 is the line parity and changes at every restart. Both are realigned on the same clock edge as the counter restart. A falling edge on vertical sync returns the parity to the first register pair.

All pins are plain control and status pins. No data stream crosses the block edge, so there is no valid/ready handshake and no back-pressure. A sync edge counts as detected at the first clock edge where the input differs from its value at the previous clock edge.

Top module: `hsync_pixel_counter`

## Requirements
- R1: While reset is asserted, and on the first clock after it is released, `pix_count` is 0 and `gain_sel` is 0.
- R2: With `sync_edge_sel` = 0, a falling edge of `hd` sampled at clock edge k makes `pix_count` 0 after clock edge k+7.
- R3: With `sync_edge_sel` = 1, the same 7-clock restart is measured from a sampled rising edge of `hd`. A falling edge then has no effect on the count.
- R4: A selected `hd` edge sampled while a restart is pending, including on the clock where the pending restart would land, cancels that restart and starts a new 7-clock wait. Exactly one restart follows.
- R5: With `hold_at_max` = 0, a count equal to `max_len` goes to 0 on the next clock when no restart lands.
- R6: With `hold_at_max` = 1, a count equal to `max_len` stays unchanged until a rising edge of `hd` is sampled. On that clock it advances to `max_len`+1, modulo 4096.
- R7: `gain_sel[0]` is 0 after every restart. It inverts on every clock on which the count advances and holds when the count is frozen, so the first pixel of a line always uses the even register of its pair.
- R8: `gain_sel[1]` inverts at every restart. A falling edge of `vd` clears it to 0 (registers 0 and 1), and the clear wins when it coincides with a restart.
- R9: Otherwise the count rises by exactly 1 per clock, modulo 4096.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hd | input | 1 | Horizontal sync |
| vd | input | 1 | Vertical sync; its falling edge clears the line parity |
| sync_edge_sel | input | 1 | 0: restart timed from the `hd` fall; 1: from the `hd` rise |
| max_len | input | 12 | Largest count value before wrap or hold |
| hold_at_max | input | 1 | 0: wrap to zero; 1: hold at `max_len` |
| pix_count | output | 12 | Current pixel index |
| gain_sel | output | 2 | Gain register index, {line parity, pixel phase} |

## Verification
A wrong restart timer shows up as a zero on `pix_count` one or more clocks away from edge k+7. The same fault shifts the phase bit for the whole rest of the line, so the error stays visible on every later clock until the next good restart. A wrong saturation or wrap compare shows within one clock of the count reaching `max_len`. A stuck parity bit shows at the next restart or the next `vd` fall. The bench compares every output on every clock against an arithmetic expectation. Each fault is therefore reported on the clock where it first appears.

// File: rtl/pixcnt_pkg.sv
package pixcnt_pkg;
  localparam int unsigned GAIN_W   = 2;
  localparam int unsigned EV_COUNT = 3;
  // event slots produced by the edge detectors
  localparam int unsigned EV_HD_FALL = 0;
  localparam int unsigned EV_HD_RISE = 1;
  localparam int unsigned EV_VD_FALL = 2;
  // polarity per slot: 1 = rising edge
  localparam logic [EV_COUNT-1:0] EV_RISING = 3'b010;
  typedef logic [GAIN_W-1:0] gain_idx_t;
endpackage

// File: rtl/pixcnt_edge_detect.sv
module pixcnt_edge_detect #(
  parameter bit RISING = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic hit
);
  logic prev;

  always_ff @(posedge clk) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= din;
  end

  generate
    if (RISING) begin : g_rise
      assign hit = din & ~prev;
    end else begin : g_fall
      assign hit = ~din & prev;
    end
  endgenerate
endmodule

// File: rtl/pixcnt_restart_delay.sv
module pixcnt_restart_delay #(
  parameter int unsigned DELAY = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic fire
);
  localparam int unsigned DLY_W = $clog2(DELAY + 1);
  localparam logic [DLY_W-1:0] LAST = DLY_W'(DELAY);

  logic             pending;
  logic [DLY_W-1:0] elapsed;

  // a fresh start on the landing clock cancels the landing
  assign fire = pending && (elapsed == LAST) && !start;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending <= 1'b0;
      elapsed <= '0;
    end else if (start) begin
      pending <= 1'b1;
      elapsed <= DLY_W'(1);
    end else if (fire) begin
      pending <= 1'b0;
      elapsed <= '0;
    end else if (pending) begin
      elapsed <= elapsed + DLY_W'(1);
    end
  end

  // independent window counter for the checks below
  localparam logic [DLY_W:0] WIN_TGT = (DLY_W+1)'(DELAY);
  localparam logic [DLY_W:0] WIN_SAT = (DLY_W+1)'(DELAY + 1);
  logic [DLY_W:0] since_start;
  always_ff @(posedge clk) begin
    if (!rst_n)                     since_start <= WIN_SAT;
    else if (start)                 since_start <= (DLY_W+1)'(1);
    else if (since_start != WIN_SAT) since_start <= since_start + (DLY_W+1)'(1);
  end

  a_r2_delay_window: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> (since_start == WIN_TGT));
  a_r4_single_restart: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !fire);
endmodule

// File: rtl/pixcnt_line_counter.sv
module pixcnt_line_counter #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             release_i,
  input  logic             hold_mode,
  input  logic [CNT_W-1:0] max_len,
  output logic [CNT_W-1:0] count,
  output logic             advance
);
  logic             at_max;
  logic             frozen;
  logic [CNT_W-1:0] count_nx;

  assign at_max  = (count == max_len);
  assign frozen  = hold_mode && at_max && !release_i;
  assign advance = !restart && !frozen;

  always_comb begin
    if (restart)                  count_nx = '0;
    else if (frozen)              count_nx = count;
    else if (!hold_mode && at_max) count_nx = '0;
    else                          count_nx = count + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) count <= '0;
    else        count <= count_nx;
  end

  a_r5_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_mode && (count == max_len) && !restart) |=> (count == '0));
  a_r6_hold_at_max: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_mode && (count == max_len) && !release_i && !restart) |=> $stable(count));
  a_r6_resume: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_mode && (count == max_len) && release_i && !restart)
      |=> (count == CNT_W'($past(count) + 1'b1)));
  a_r9_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && (count != max_len)) |=> (count == CNT_W'($past(count) + 1'b1)));
endmodule

// File: rtl/pixcnt_gain_steer.sv
module pixcnt_gain_steer
  import pixcnt_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      restart,
  input  logic      advance,
  input  logic      frame_start,
  output gain_idx_t gain_sel
);
  logic parity;
  logic phase;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      parity <= 1'b0;
      phase  <= 1'b0;
    end else begin
      if (frame_start)  parity <= 1'b0;
      else if (restart) parity <= ~parity;
      if (restart)      phase <= 1'b0;
      else if (advance) phase <= ~phase;
    end
  end

  assign gain_sel = {parity, phase};

  a_r7_first_even: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (gain_sel[0] == 1'b0));
  a_r7_alternate: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !restart) |=> (gain_sel[0] != $past(gain_sel[0])));
  a_r8_frame_clear: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (gain_sel[1] == 1'b0));
  a_r8_line_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && !frame_start) |=> (gain_sel[1] != $past(gain_sel[1])));
endmodule

// File: rtl/hsync_pixel_counter.sv
module hsync_pixel_counter
  import pixcnt_pkg::*;
#(
  parameter int unsigned CNT_W       = 12,
  parameter int unsigned RESTART_DLY = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hd,
  input  logic             vd,
  input  logic             sync_edge_sel,
  input  logic [CNT_W-1:0] max_len,
  input  logic             hold_at_max,
  output logic [CNT_W-1:0] pix_count,
  output logic [1:0]       gain_sel
);
  logic [EV_COUNT-1:0] ev_src;
  logic [EV_COUNT-1:0] ev_hit;
  logic                restart_start;
  logic                restart_fire;
  logic                pix_advance;
  gain_idx_t           gsel;

  assign ev_src[EV_HD_FALL] = hd;
  assign ev_src[EV_HD_RISE] = hd;
  assign ev_src[EV_VD_FALL] = vd;

  for (genvar i = 0; i < EV_COUNT; i++) begin : g_ev
    pixcnt_edge_detect #(.RISING(EV_RISING[i])) u_det (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (ev_src[i]),
      .hit  (ev_hit[i])
    );
  end

  assign restart_start = sync_edge_sel ? ev_hit[EV_HD_RISE] : ev_hit[EV_HD_FALL];

  pixcnt_restart_delay #(.DELAY(RESTART_DLY)) u_delay (
    .clk  (clk),
    .rst_n(rst_n),
    .start(restart_start),
    .fire (restart_fire)
  );

  pixcnt_line_counter #(.CNT_W(CNT_W)) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (restart_fire),
    .release_i(ev_hit[EV_HD_RISE]),
    .hold_mode(hold_at_max),
    .max_len  (max_len),
    .count    (pix_count),
    .advance  (pix_advance)
  );

  pixcnt_gain_steer u_gain (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart    (restart_fire),
    .advance    (pix_advance),
    .frame_start(ev_hit[EV_VD_FALL]),
    .gain_sel   (gsel)
  );

  assign gain_sel = gsel;

  a_r2_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
    restart_fire |=> (pix_count == '0));
  a_r1_gain_zero_on_reset: assert property (@(posedge clk)
    !rst_n |=> ((pix_count == '0) && (gain_sel == 2'b00)));
endmodule

// File: tb/hsync_pixel_counter_test.sv
module hsync_pixel_counter_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        hd, vd, sync_edge_sel, hold_at_max;
  logic [11:0] max_len;
  logic [11:0] pix_count;
  logic [1:0]  gain_sel;

  always #10 clk = ~clk;

  hsync_pixel_counter uut (
    .clk(clk), .rst_n(rst_n), .hd(hd), .vd(vd), .sync_edge_sel(sync_edge_sel),
    .max_len(max_len), .hold_at_max(hold_at_max),
    .pix_count(pix_count), .gain_sel(gain_sel)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  int cyc, sched, exp_cnt, exp_ph, exp_par;
  logic m_hd, m_vd;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  // drive inputs right after a negedge, predict the next posedge, compare
  task automatic step(input logic nhd, input logic nvd, input string tag);
    logic rise, fall, sel, vfall, fire, frz;
    hd = nhd; vd = nvd;
    rise  = nhd && !m_hd;
    fall  = !nhd && m_hd;
    sel   = sync_edge_sel ? rise : fall;
    vfall = !nvd && m_vd;
    fire  = (sched == cyc + 1) && !sel;
    frz   = hold_at_max && (exp_cnt == int'(max_len)) && !rise;
    if (sel)       sched = cyc + 1 + 7;
    else if (fire) sched = -1;
    if (fire)                                            exp_cnt = 0;
    else if (frz)                                        exp_cnt = exp_cnt;
    else if (!hold_at_max && exp_cnt == int'(max_len))   exp_cnt = 0;
    else                                                 exp_cnt = (exp_cnt + 1) % 4096;
    if (fire)      exp_ph = 0;
    else if (!frz) exp_ph = 1 - exp_ph;
    if (vfall)     exp_par = 0;
    else if (fire) exp_par = 1 - exp_par;
    m_hd = nhd; m_vd = nvd;
    @(negedge clk);
    cyc++;
    chk(tag, int'(pix_count), exp_cnt);
    chk("R7 phase", int'(gain_sel[0]), exp_ph);
    chk("R8 parity", int'(gain_sel[1]), exp_par);
  endtask

  task automatic line_restart();
    step(1'b1, 1'b0, "R2");
    repeat (8) step(1'b0, 1'b0, "R2");
  endtask

  initial begin
    rst_n = 1'b0; hd = 1'b0; vd = 1'b0; sync_edge_sel = 1'b0;
    hold_at_max = 1'b0; max_len = 12'd4095;
    cyc = 0; sched = -1; exp_cnt = 0; exp_ph = 0; exp_par = 0;
    m_hd = 1'b0; m_vd = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 count", int'(pix_count), 0);
    chk("R1 gain", int'(gain_sel), 0);
    rst_n = 1'b1;

    // R9: free running after reset
    for (int i = 0; i < 20; i++) step(1'b0, 1'b0, "R9");

    // R2: falling-edge timing over pulse widths
    sync_edge_sel = 1'b0;
    for (int w = 1; w <= 10; w++) begin
      repeat (w)  step(1'b1, 1'b0, "R2");
      repeat (12) step(1'b0, 1'b0, "R2");
    end

    // R3: rising-edge timing, falls inside the wait must not matter
    sync_edge_sel = 1'b1;
    for (int w = 1; w <= 10; w++) begin
      repeat (w)  step(1'b1, 1'b0, "R3");
      repeat (12) step(1'b0, 1'b0, "R3");
    end

    // R4: second fall arrives 2..9 clocks after the first
    sync_edge_sel = 1'b0;
    for (int g = 0; g <= 7; g++) begin
      step(1'b1, 1'b0, "R4");
      step(1'b0, 1'b0, "R4");
      repeat (g) step(1'b0, 1'b0, "R4");
      step(1'b1, 1'b0, "R4");
      repeat (12) step(1'b0, 1'b0, "R4");
    end

    // R5: wrap over several maxima
    for (int m = 2; m <= 9; m++) begin
      max_len = 12'd4095;
      line_restart();
      max_len = 12'(m);
      repeat (3 * (m + 1) + 2) step(1'b0, 1'b0, "R5");
    end

    // R6: hold at maximum, released by the hd rise
    hold_at_max = 1'b1;
    for (int m = 3; m <= 6; m++) begin
      max_len = 12'd4095;
      line_restart();
      max_len = 12'(m);
      repeat (m + 6) step(1'b0, 1'b0, "R6");
      repeat (3)     step(1'b1, 1'b0, "R6");
      repeat (10)    step(1'b0, 1'b0, "R6");
    end
    hold_at_max = 1'b0;
    max_len = 12'd4095;

    // R8: vd fall at several offsets around a restart
    for (int o = 0; o <= 9; o++) begin
      step(1'b1, 1'b1, "R8");
      repeat (o)  step(1'b0, 1'b1, "R8");
      step(1'b0, 1'b0, "R8");
      repeat (10) step(1'b0, 1'b0, "R8");
      line_restart();
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule